// File: doc/BRIEF.md
# AAL5 CRC-32 Word-Parallel Generator

This block keeps a running AAL5 CRC-32 remainder and updates it with one 32-bit word per clock. The current remainder is always visible on its output. A transmit path feeds each payload word with a valid qualifier. On the last word it raises a seal strobe, and the register then takes the bitwise inverse of the updated remainder. That value is the one placed in the packet trailer.

When cells of different packets interleave, the surrounding logic reads the remainder out at a packet change and keeps it elsewhere. To resume that packet later, it drives the stored value on the preload bus and pulses the load strobe. A new packet starts with a load of all ones.

Each cycle, a small decoder turns the three strobes into one enumerated operation: OP_HOLD, OP_LOAD, OP_ACCUM, OP_SEAL or OP_FLIP. The remainder register acts on that operation. Every cycle is one independent transition into the register, chosen by priority. OP_LOAD comes from the load strobe alone and has the highest priority. OP_SEAL is valid plus seal. OP_ACCUM is valid without seal. OP_FLIP is seal without valid. OP_HOLD covers every other case.

Top module: `crc32w_gen`

## Requirements
- R1: While rst is high at a clock edge, crc_o is 32'h0000_0000 after that edge.
- R2: With load_i high, crc_o equals load_val_i one clock later.
- R3: With word_vld_i high and load_i and seal_i low, the register advances by one word. The polynomial is 32'h04C11DB7, applied MSB-first with no reflection and no output inversion, and word_i bit 31 is shifted in first.
- R4: With load_i, word_vld_i and seal_i all low, crc_o does not change.
- R5: load_i takes priority over word_vld_i and seal_i. The word and the seal strobe in that cycle have no effect, and crc_o equals load_val_i one clock later.
- R6: With word_vld_i and seal_i high together (and load_i low), crc_o becomes the bitwise inverse of the R3 update. When a fresh all-ones run covers the payload words followed by that trailer word, with no seal, it ends at 32'hC704DD7B.
- R7: With seal_i high and word_vld_i and load_i low, crc_o becomes the bitwise inverse of its current value.
- R8: A packet is split across cells, its remainder is saved, other traffic passes, and the saved value is then reloaded. The packet's final result equals the result of an uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the remainder |
| word_i | input | 32 | Payload word, bit 31 enters the CRC first |
| word_vld_i | input | 1 | Qualifies word_i for this cycle |
| load_i | input | 1 | Load strobe for the preload value |
| load_val_i | input | 32 | Preload value (all ones for a new packet, saved remainder to resume) |
| seal_i | input | 1 | Seal strobe: invert the remainder to form the trailer word |
| crc_o | output | 32 | Current remainder register |

## Verification
Every operation lands in the single remainder register. Its effect appears on crc_o exactly one clock edge after the strobes are sampled, and no pipeline stage sits between the inputs and the register. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares crc_o with a bench-side model on the next falling edge, so every check sits one cycle after its stimulus. For the R6 residue check, the bench runs the stored payload and trailer words back through the block and compares the result against a fixed constant, not against the model.

// File: rtl/crc32w_pkg.sv
package crc32w_pkg;

    // Operation chosen for the remainder register each cycle
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ACCUM = 3'd2,
        OP_SEAL  = 3'd3,
        OP_FLIP  = 3'd4
    } crc_op_e;

    localparam logic [31:0] AAL5_POLY = 32'h04C1_1DB7;

endpackage

// File: rtl/crc32w_op_decode.sv
module crc32w_op_decode
    import crc32w_pkg::*;
(
    input  logic    load_i,
    input  logic    vld_i,
    input  logic    seal_i,
    output crc_op_e op_o
);

    // Priority: load, then data (with or without seal), then lone seal
    always_comb begin
        if (load_i) begin
            op_o = OP_LOAD;
        end else if (vld_i && seal_i) begin
            op_o = OP_SEAL;
        end else if (vld_i) begin
            op_o = OP_ACCUM;
        end else if (seal_i) begin
            op_o = OP_FLIP;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/crc32w_step.sv
module crc32w_step #(
    parameter int          CRC_W  = 32,
    parameter int          DATA_W = 32,
    parameter logic [CRC_W-1:0] POLY = CRC_W'(32'h04C1_1DB7)
) (
    input  logic [CRC_W-1:0]  rem_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  rem_o
);

    localparam int TOP = CRC_W - 1;

    // Serial MSB-first update unrolled over the whole word
    function automatic logic [CRC_W-1:0] advance(
        input logic [CRC_W-1:0]  r_in,
        input logic [DATA_W-1:0] d_in
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = r_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = r[TOP] ^ d_in[i];
            r  = {r[TOP-1:0], 1'b0};
            if (fb) begin
                r = r ^ POLY;
            end
        end
        return r;
    endfunction

    assign rem_o = advance(rem_i, data_i);

endmodule

// File: rtl/crc32w_gen.sv
module crc32w_gen
    import crc32w_pkg::*;
#(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_i,
    input  logic              word_vld_i,
    input  logic              load_i,
    input  logic [CRC_W-1:0]  load_val_i,
    input  logic              seal_i,
    output logic [CRC_W-1:0]  crc_o
);

    localparam logic [CRC_W-1:0] RST_VAL = '0;

    crc_op_e          op;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_upd;

    crc32w_op_decode u_dec (
        .load_i (load_i),
        .vld_i  (word_vld_i),
        .seal_i (seal_i),
        .op_o   (op)
    );

    crc32w_step #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (CRC_W'(AAL5_POLY))
    ) u_step (
        .rem_i  (rem_q),
        .data_i (word_i),
        .rem_o  (rem_upd)
    );

    // Remainder register: one transition per operation
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= RST_VAL;
        end else begin
            unique case (op)
                OP_LOAD:  rem_q <= load_val_i;
                OP_ACCUM: rem_q <= rem_upd;
                OP_SEAL:  rem_q <= ~rem_upd;
                OP_FLIP:  rem_q <= ~rem_q;
                default:  rem_q <= rem_q;
            endcase
        end
    end

    // Output process
    always_comb begin
        crc_o = rem_q;
    end

endmodule

// File: rtl/crc32w_gen_chk.sv
module crc32w_gen_chk #(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              word_vld_i,
    input logic              load_i,
    input logic [CRC_W-1:0]  load_val_i,
    input logic              seal_i,
    input logic [CRC_W-1:0]  crc_o
);

    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: the edge after a reset cycle leaves the output cleared
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_clears : assert (crc_o == '0);
        end
    end

    // R2 and R5: the load strobe wins and loads the preload value
    a_r2_load_value : assert property (@(posedge clk) disable iff (rst)
        load_i |=> crc_o == $past(load_val_i));

    // R4: with no strobe the remainder is held
    a_r4_idle_hold : assert property (@(posedge clk) disable iff (rst)
        (!load_i && !word_vld_i && !seal_i) |=> $stable(crc_o));

    // R7: a lone seal inverts the current remainder
    a_r7_lone_seal : assert property (@(posedge clk) disable iff (rst)
        (!load_i && !word_vld_i && seal_i) |=> crc_o == ~$past(crc_o));

    // R5: a load that comes with data is not modified by that data
    a_r5_load_priority : assert property (@(posedge clk) disable iff (rst)
        (load_i && word_vld_i && seal_i) |=> crc_o == $past(load_val_i));

endmodule

bind crc32w_gen crc32w_gen_chk #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_vld_i (word_vld_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .seal_i     (seal_i),
    .crc_o      (crc_o)
);

// File: tb/crc32w_gen_test.sv
module crc32w_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] word_i = '0;
    logic        word_vld_i = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] load_val_i = '0;
    logic        seal_i = 1'b0;
    logic [31:0] crc_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q = '0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] pkt [0:8];

    always #4 clk = ~clk;

    crc32w_gen uut (
        .clk        (clk),
        .rst        (rst),
        .word_i     (word_i),
        .word_vld_i (word_vld_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .seal_i     (seal_i),
        .crc_o      (crc_o)
    );

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ 32'h04C1_1DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (crc_o !== exp) begin
            errors++;
            $display("FAIL %s: crc_o=%h expected=%h", req, crc_o, exp);
        end
    endtask

    // Drive one cycle, advance the bench model, check after the edge
    task automatic cyc(input string req, input logic ld, input logic [31:0] lv,
                       input logic v, input logic [31:0] w, input logic s);
        @(negedge clk);
        load_i = ld; load_val_i = lv; word_vld_i = v; word_i = w; seal_i = s;
        if (ld)          exp_q = lv;
        else if (v && s) exp_q = ~ref_step(exp_q, w);
        else if (v)      exp_q = ref_step(exp_q, w);
        else if (s)      exp_q = ~exp_q;
        @(posedge clk);
        @(negedge clk);
        load_i = 0; word_vld_i = 0; seal_i = 0;
        check(req, exp_q);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: crc_o=%h expected=done", crc_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        logic [31:0] trailer;
        // R1: reset clears
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 32'h0);
        rst = 0;
        exp_q = 0;

        // R4: idle cycles hold
        repeat (3) cyc("R4", 0, 0, 0, 0, 0);

        // R2 and R3: one-hot word sweep from all ones and from zero
        for (int b = 0; b < 32; b++) begin
            cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
            cyc("R3", 0, 0, 1, 32'h1 << b, 0);
            cyc("R2", 1, 32'h0, 0, 0, 0);
            cyc("R3", 0, 0, 1, 32'h1 << b, 0);
        end

        // R6: packets of length 1..8 sealed on the last word, residue check
        for (int len = 1; len <= 8; len++) begin
            cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
            for (int k = 0; k < len; k++) begin
                seed = next_rand(seed);
                pkt[k] = seed;
                cyc((k == len - 1) ? "R6" : "R3", 0, 0, 1, seed, k == len - 1);
            end
            trailer = crc_o;
            cyc("R4", 0, 0, 0, 0, 0);
            cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
            for (int k = 0; k < len; k++) cyc("R3", 0, 0, 1, pkt[k], 0);
            cyc("R6", 0, 0, 1, trailer, 0);
            check("R6", 32'hC704_DD7B);
        end

        // R5: load wins over data and seal
        cyc("R3", 0, 0, 1, 32'hDEAD_BEEF, 0);
        cyc("R5", 1, 32'hA5A5_0F0F, 1, 32'h1357_9BDF, 1);
        cyc("R5", 1, 32'h0123_4567, 1, 32'hFFFF_0000, 0);
        cyc("R5", 1, 32'h89AB_CDEF, 0, 0, 1);
        cyc("R4", 0, 0, 0, 0, 0);

        // R7: lone seal inverts, twice restores
        cyc("R7", 0, 0, 0, 0, 1);
        cyc("R7", 0, 0, 0, 0, 1);
        check("R7", 32'h89AB_CDEF);

        // R8: interleaved cells with save and restore
        begin
            logic [31:0] w8 [0:5];
            logic [31:0] whole;
            for (int k = 0; k < 6; k++) begin
                seed = next_rand(seed);
                w8[k] = seed;
            end
            whole = 32'hFFFF_FFFF;
            for (int k = 0; k < 5; k++) whole = ref_step(whole, w8[k]);
            whole = ~ref_step(whole, w8[5]);
            cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
            for (int k = 0; k < 3; k++) cyc("R3", 0, 0, 1, w8[k], 0);
            saved = crc_o;
            cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
            cyc("R3", 0, 0, 1, 32'hCAFE_F00D, 0);
            cyc("R3", 0, 0, 1, 32'h0BAD_C0DE, 0);
            cyc("R8", 1, saved, 0, 0, 0);
            for (int k = 3; k < 6; k++) cyc("R8", 0, 0, 1, w8[k], k == 5);
            check("R8", whole);
        end

        // R1: reset in the middle of a packet
        cyc("R3", 0, 0, 1, 32'h5555_AAAA, 0);
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        check("R1", 32'h0);
        rst = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule